// File: doc/BRIEF.md
# Scratchpad / Mode-Register Swap with FIFO Level Readback

This register slice sits in the host-facing side of a UART. One host address is shared by two registers. The first is an 8-bit general-purpose scratchpad. The second is a write-only mode register. A swap control input decides which register a host write reaches. When swap is low, the address acts as a plain read/write scratchpad.

When swap is high, a write lands in the mode register. A read of the same address then returns a FIFO fill count instead of the scratchpad. Two mode bits choose the count: the receive count, the transmit count, or the two taken in turn on successive reads. Levels wider than eight bits saturate at 0xFF.

The mode register also carries two controls for the transmit path. One is a one-shot flag that tells the transmitter to send the next byte straight away. It drops by itself when the transmitter reports that the byte has gone out. The other is a level-invert control for the RTS line when the port runs in RS485 mode.

Top module: `scratch_swap_regs`

## Requirements
- R1: After reset the scratchpad holds 0xFF, the mode register is all zeros (so `sendNow` and `rtsInvert` are 0), and the alternate readback phase points at the receive count.
- R2: With `swapEn` low, a write stores `hostWdata` in the scratchpad and `readData` shows the scratchpad, whatever the stored mode bits are.
- R3: With `swapEn` high, a write updates the mode register from `hostWdata[3:0]` and leaves the scratchpad unchanged; bits [7:4] of the write are ignored.
- R4: With `swapEn` high and mode bit 0 equal to 0, `readData` shows the receive level.
- R5: With `swapEn` high and mode bits [1:0] equal to 01, `readData` shows the transmit level.
- R6: With `swapEn` high and mode bits [1:0] equal to 11, the first read after a mode write shows the receive level. Each completed read strobe (`hostRd` high at a clock edge) then flips the selection between transmit and receive; idle cycles do not flip it, and any mode write returns it to receive.
- R7: `sendNow` follows mode bit 2 when the mode register is written. It clears the cycle after a `byteSent` pulse. A mode write in the same cycle as `byteSent` takes priority.
- R8: `rtsInvert` equals mode bit 3 (0 = RTS low while transmitting, 1 = RTS high).
- R9: A level above 255 reads as 0xFF; a level of 255 or less reads as its own value (a full 128-entry FIFO reads 0x80).
- R10: `sleepMode` has no effect on the scratchpad contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Write strobe for the shared address |
| hostRd | input | 1 | Read strobe for the shared address |
| hostWdata | input | 8 | Write data |
| swapEn | input | 1 | 1 routes the address to the mode register and level readback |
| sleepMode | input | 1 | Sleep indication |
| rxLevel | input | LVL_W | Receive FIFO fill count |
| txLevel | input | LVL_W | Transmit FIFO fill count |
| byteSent | input | 1 | One-cycle pulse when the transmitter finishes a byte |
| readData | output | 8 | Read data for the shared address |
| sendNow | output | 1 | Send the next byte immediately, bypassing the queue |
| rtsInvert | output | 1 | RTS level during transmit in RS485 mode |

## Verification
The embedded properties check the following on every cycle: the scratchpad holds still unless it is written, a mode write resets the alternate phase, each alternate-mode read strobe flips the phase, `sendNow` clears after `byteSent`, and `rtsInvert` follows the written bit. Whether reads actually show the right count in the right order depends on sequences over several cycles. Those sequences are a first read after a mode change, idle gaps between reads, saturated levels, and a write coinciding with `byteSent`. Only the bench scenarios show those, by comparing against a behavioural model on every clock.

// File: rtl/scratch_swap_pkg.sv
package scratch_swap_pkg;
  localparam int DATA_W = 8;
  localparam int MODE_W = 4;
  localparam int BIT_SEL0 = 0;
  localparam int BIT_SEL1 = 1;
  localparam int BIT_SEND = 2;
  localparam int BIT_RTS  = 3;

  typedef struct packed {
    logic scratchWe;
    logic modeWe;
    logic sendClr;
    logic selTx;
  } ctrlStrobes_t;
endpackage

// File: rtl/scratch_swap_ctrl.sv
module scratch_swap_ctrl
  import scratch_swap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         swapEn,
  input  logic         byteSent,
  input  logic [1:0]   modeSel,
  output ctrlStrobes_t strobes
);
  logic phaseTx;
  logic altMode;
  logic phaseFlip;

  assign altMode   = (modeSel == 2'b11);
  assign phaseFlip = hostRd && swapEn && altMode && !strobes.modeWe;

  always_comb begin
    strobes.scratchWe = hostWr && !swapEn;
    strobes.modeWe    = hostWr && swapEn;
    strobes.sendClr   = byteSent;
    strobes.selTx     = swapEn && modeSel[0] && (!modeSel[1] || phaseTx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseTx <= 1'b0;
    else if (strobes.modeWe) phaseTx <= 1'b0;
    else if (phaseFlip)      phaseTx <= !phaseTx;
  end

  AST_PHASE_CLEARS_ON_MODE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && swapEn) |=> !phaseTx); // R6
  AST_PHASE_FLIPS_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && swapEn && modeSel == 2'b11 && !hostWr) |=> (phaseTx != $past(phaseTx))); // R6
  AST_PHASE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!hostRd && !hostWr) |=> $stable(phaseTx)); // R6
endmodule

// File: rtl/scratch_swap_datapath.sv
module scratch_swap_datapath
  import scratch_swap_pkg::*;
#(
  parameter int LVL_W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic               swapEn,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   txLevel,
  output logic [DATA_W-1:0]  readData,
  output logic [1:0]         modeSel,
  output logic               sendNow,
  output logic               rtsInvert
);
  logic [DATA_W-1:0] scratchReg;
  logic [MODE_W-1:0] modeReg;
  logic [DATA_W-1:0] rxSat;
  logic [DATA_W-1:0] txSat;

  generate
    if (LVL_W > DATA_W) begin : g_sat
      assign rxSat = (|rxLevel[LVL_W-1:DATA_W]) ? {DATA_W{1'b1}} : rxLevel[DATA_W-1:0];
      assign txSat = (|txLevel[LVL_W-1:DATA_W]) ? {DATA_W{1'b1}} : txLevel[DATA_W-1:0];
    end else begin : g_ext
      assign rxSat = DATA_W'(rxLevel);
      assign txSat = DATA_W'(txLevel);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  scratchReg <= {DATA_W{1'b1}};
    else if (strobes.scratchWe) scratchReg <= hostWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               modeReg <= '0;
    else if (strobes.modeWe) modeReg <= hostWdata[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sendNow <= 1'b0;
    else if (strobes.modeWe)  sendNow <= hostWdata[BIT_SEND];
    else if (strobes.sendClr) sendNow <= 1'b0;
  end

  assign modeSel   = {modeReg[BIT_SEL1], modeReg[BIT_SEL0]};
  assign rtsInvert = modeReg[BIT_RTS];

  always_comb begin
    if (!swapEn)            readData = scratchReg;
    else if (strobes.selTx) readData = txSat;
    else                    readData = rxSat;
  end

  AST_SCRATCH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.scratchWe |=> $stable(scratchReg)); // R3
  AST_SEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sendClr && !strobes.modeWe) |=> !sendNow); // R7
  AST_RTS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.modeWe |=> (rtsInvert == $past(hostWdata[BIT_RTS]))); // R8
  AST_SCRATCH_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (!swapEn && strobes.scratchWe) |=> (swapEn || readData == $past(hostWdata))); // R2
endmodule

// File: rtl/scratch_swap_regs.sv
module scratch_swap_regs
  import scratch_swap_pkg::*;
#(
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [7:0]       hostWdata,
  input  logic             swapEn,
  input  logic             sleepMode,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             byteSent,
  output logic [7:0]       readData,
  output logic             sendNow,
  output logic             rtsInvert
);
  ctrlStrobes_t strobes;
  logic [1:0]   modeSel;
  logic         sleepUnused;

  // R10: sleep does not gate any register
  assign sleepUnused = sleepMode;

  scratch_swap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .swapEn(swapEn), .byteSent(byteSent), .modeSel(modeSel), .strobes(strobes)
  );

  scratch_swap_datapath #(.LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostWdata(hostWdata),
    .swapEn(swapEn), .rxLevel(rxLevel), .txLevel(txLevel), .readData(readData),
    .modeSel(modeSel), .sendNow(sendNow), .rtsInvert(rtsInvert)
  );
endmodule

// File: tb/scratch_swap_regs_bench.sv
module scratch_swap_regs_bench;
  localparam int LVL_W = 9;
  logic clk = 0, rstN = 0, hostWr = 0, hostRd = 0, swapEn = 0, sleepMode = 0, byteSent = 0;
  logic [7:0] hostWdata = 0;
  logic [LVL_W-1:0] rxLevel = 0, txLevel = 0;
  logic [7:0] readData;
  logic sendNow, rtsInvert;
  int nRun = 0, nFail = 0;
  bit done = 0;

  // behavioural reference state
  int mScr = 255, mMode = 0, mSend = 0, mPh = 0;

  always #4 clk = ~clk;

  scratch_swap_regs #(.LVL_W(LVL_W)) u_scratch_swap_regs (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostWdata(hostWdata),
    .swapEn(swapEn), .sleepMode(sleepMode), .rxLevel(rxLevel), .txLevel(txLevel),
    .byteSent(byteSent), .readData(readData), .sendNow(sendNow), .rtsInvert(rtsInvert)
  );

  function automatic int satOf(int v);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int expRead();
    if (!swapEn) return mScr;
    if ((mMode % 2) == 0) return satOf(int'(rxLevel));
    if ((mMode % 4) == 1) return satOf(int'(txLevel));
    return (mPh != 0) ? satOf(int'(txLevel)) : satOf(int'(rxLevel));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mScr = 255; mMode = 0; mSend = 0; mPh = 0;
    end else if (hostWr && swapEn) begin
      mMode = int'(hostWdata[3:0]); mSend = int'(hostWdata[2]); mPh = 0;
    end else begin
      if (hostWr) mScr = int'(hostWdata);
      if (byteSent) mSend = 0;
      if (hostRd && swapEn && (mMode % 4) == 3) mPh = 1 - mPh;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (rstN && !done) begin
      if (!swapEn) chk("R2 scratch readback", int'(readData), expRead());
      else if ((mMode % 2) == 0) chk("R4 rx readback", int'(readData), expRead());
      else if ((mMode % 4) == 1) chk("R5 tx readback", int'(readData), expRead());
      else chk("R6 alternate readback", int'(readData), expRead());
      chk("R7 sendNow model", int'(sendNow), mSend);
      chk("R8 rtsInvert model", int'(rtsInvert), (mMode / 8) % 2);
    end
  end

  task automatic wr(logic sw, logic [7:0] d);
    @(negedge clk); swapEn = sw; hostWr = 1; hostWdata = d;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic rd(string tag, int exp);
    @(negedge clk); hostRd = 1; #2;
    chk(tag, int'(readData), exp);
    @(negedge clk); hostRd = 0;
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rxLevel = 9'd17; txLevel = 9'd99;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset scratch", int'(readData), 255);
    chk("R1 reset sendNow", int'(sendNow), 0);
    chk("R1 reset rtsInvert", int'(rtsInvert), 0);
    rstN = 1;
    rd("R1 scratch after reset", 255);
    wr(0, 8'h5A);
    rd("R2 scratch write", 8'h5A);
    @(negedge clk); sleepMode = 1;
    repeat (4) @(negedge clk);
    rd("R10 scratch kept in sleep", 8'h5A);
    sleepMode = 0;
    wr(1, 8'h02);
    rd("R4 rx with bits 10", 17);
    wr(1, 8'h00);
    rd("R4 rx with bits 00", 17);
    wr(1, 8'h02);
    @(negedge clk); swapEn = 0;
    rd("R3 scratch untouched by mode write", 8'h5A);
    rd("R2 scratch with mode bits 10", 8'h5A);
    wr(1, 8'h01);
    rd("R5 tx level", 99);
    wr(1, 8'h03);
    rd("R6 first read rx", 17);
    repeat (3) @(negedge clk);
    rd("R6 second read tx after idle", 99);
    rd("R6 third read rx", 17);
    wr(1, 8'h03);
    rd("R6 rewrite returns to rx", 17);
    rd("R6 then tx", 99);
    wr(1, 8'h00);
    rxLevel = 9'd300;
    rd("R9 saturate", 255);
    rxLevel = 9'd128;
    rd("R9 full fifo", 128);
    rxLevel = 9'd255;
    rd("R9 edge 255", 255);
    wr(1, 8'h04);
    #2 chk("R7 sendNow set", int'(sendNow), 1);
    @(negedge clk); byteSent = 1;
    @(negedge clk); byteSent = 0; #2;
    chk("R7 sendNow self-clears", int'(sendNow), 0);
    @(negedge clk); hostWr = 1; hostWdata = 8'h04; byteSent = 1;
    @(negedge clk); hostWr = 0; byteSent = 0; #2;
    chk("R7 write beats byteSent", int'(sendNow), 1);
    wr(1, 8'h08);
    #2 chk("R8 rts invert set", int'(rtsInvert), 1);
    chk("R7 sendNow cleared by write", int'(sendNow), 0);
    wr(1, 8'hF0);
    #2 chk("R8 rts cleared upper bits ignored", int'(rtsInvert), 0);
    rd("R3 upper bits ignored, rx mode", 255);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule